// File: doc/BRIEF.md
# Double-Buffered Compare PWM Timer

This block is an up-counting pulse-width modulator with a width set by parameter (8 bits by default). A period register sets the count at which the counter returns to zero. A compare register sets the duty cycle. One PWM pin is driven, and its sense comes from a two-bit output mode input. Two sticky event flags, overflow and compare match, feed an interrupt controller. A simple register bus has a write strobe, a write address and a combinational read port, and it reaches the period register, the compare register and the flags.

Compare writes never reach the comparator directly. They land in a holding register that reads back at once. A small buffer state machine records that an update is waiting. It has two states: `BUF_IDLE` (nothing waiting) and `BUF_PENDING` (the holding value differs from the active value). The transition `BUF_IDLE -> BUF_PENDING` occurs on any compare write. The transition `BUF_PENDING -> BUF_IDLE` occurs on a counter wrap when no compare write arrives in the same cycle. A write that arrives together with a wrap keeps the machine in `BUF_PENDING`. The active compare value therefore changes only at the period boundary, so no pulse is ever cut short or doubled.

Top module: `bufpwm_timer`

## Requirements
- R1: After reset the period register reads 0xFF and the compare register reads 0x00. The overflow flag (bit 0 at address 2) and the compare flag (bit 1 at address 2) read 0, and `pwm_out` is low.
- R2: The counter advances by one on each clock edge where `cnt_en` is 1 and holds its value while `cnt_en` is 0. When it advances from a count at or above the period value, it returns to 0x00.
- R3: A write to address 1 loads the period register, and a read of address 1 returns it.
- R4: A write to address 0 goes to the holding register, and a read of address 0 returns the written value from the next cycle on. The active compare value is left unchanged by this write.
- R5: The active compare value takes the holding value only at a counter wrap (`BUF_PENDING` and wrap). It therefore stays stable for the rest of the period in which a write occurs.
- R6: With mode 2'b10 and an active compare value strictly between 0 and the period value, `pwm_out` is high while the count is below the compare value and low otherwise.
- R7: With mode 2'b11 and an active compare value strictly between 0 and the period value, `pwm_out` is the inverse of the mode 2'b10 level.
- R8: An active compare value of 0 holds `pwm_out` low in mode 2'b10 and high in mode 2'b11. A value equal to or above the period value holds it high in mode 2'b10 and low in mode 2'b11.
- R9: With mode 2'b00 or 2'b01 the PWM output is disconnected and `pwm_out` stays low.
- R10: The overflow flag is set on every wrap. Writing a 1 to bit 0 of address 2 clears it, and writing a 0 there leaves it alone. A set in the same cycle wins over a clear.
- R11: The compare flag is set on a clock edge where `cnt_en` is 1 and the count equals the active compare value. Writing a 1 to bit 1 of address 2 clears it, and a set wins over a clear.
- R12: `irq_ovf` is the overflow flag ANDed with `ovf_ie` and `glob_ie`. `irq_cmp` is the compare flag ANDed with `cmp_ie` and `glob_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable (one tick per cycle when high) |
| mode | input | 2 | Output mode: 00/01 off, 10 non-inverted, 11 inverted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare, 1 period, 2 flags |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address (same map) |
| rd_data | output | W | Combinational read data |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| pwm_out | output | 1 | PWM output pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
The bench uses a period of 5. It sweeps every compare value from 0 to the period value in all four modes and compares every cycle of a full period against a counting model. A design that treated 0 or the period value as ordinary thresholds would show a one-count spike or notch where a constant level belongs. A design that loaded the compare value at once would change the output mid-period after a write, and the bench catches this with a write placed at count 2 that would flip the level at count 3. The bench also checks flag set-versus-clear priority, writes of zero to the flag register, and counter hold with the enable low. A design with the wrong clear sense, or one that counted freely, would set or lose a flag at the wrong cycle.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;

    typedef enum logic {
        BUF_IDLE    = 1'b0,
        BUF_PENDING = 1'b1
    } buf_state_t;

    localparam logic [1:0] ADDR_CMP  = 2'd0;
    localparam logic [1:0] ADDR_TOP  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam logic [1:0] MODE_OFF    = 2'b00;
    localparam logic [1:0] MODE_OFF_B  = 2'b01;
    localparam logic [1:0] MODE_NONINV = 2'b10;
    localparam logic [1:0] MODE_INV    = 2'b11;

    localparam int FLAG_OVF_BIT = 0;
    localparam int FLAG_CMP_BIT = 1;

endpackage

// File: rtl/bufpwm_counter.sv
module bufpwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = tick && (cnt_q >= top);
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: wrap returns to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    // R2: no tick, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/bufpwm_cmpbuf.sv
module bufpwm_cmpbuf
    import bufpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmp,
    input  logic [W-1:0] wr_data,
    input  logic         wrap,
    output logic [W-1:0] hold_val,
    output logic [W-1:0] act_val
);
    buf_state_t   state_q, state_d;
    logic [W-1:0] hold_q, act_q;
    logic         load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_IDLE:    if (wr_cmp)          state_d = BUF_PENDING;
            BUF_PENDING: if (wrap && !wr_cmp) state_d = BUF_IDLE;
            default:                          state_d = BUF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_IDLE;
        else        state_q <= state_d;
    end

    assign load = (state_q == BUF_PENDING) && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr_cmp) hold_q <= wr_data;
            if (load)   act_q  <= hold_q;
        end
    end

    assign hold_val = hold_q;
    assign act_val  = act_q;

    // R4: written value visible in holding register next cycle
    a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> (hold_val == $past(wr_data)));

    // R5: active value moves only at a wrap
    a_r5_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_val));

    // R5: pending value taken at wrap
    a_r5_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act_val == $past(hold_val)));

endmodule

// File: rtl/bufpwm_outgen.sv
module bufpwm_outgen
    import bufpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] act,
    input  logic [W-1:0] top,
    output logic         pwm
);
    logic base;

    always_comb begin
        if (act == '0)
            base = 1'b0;
        else if (act >= top)
            base = 1'b1;
        else
            base = (cnt < act);
    end

    always_comb begin
        unique case (mode)
            MODE_NONINV:          pwm = base;
            MODE_INV:             pwm = !base;
            MODE_OFF, MODE_OFF_B: pwm = 1'b0;
            default:              pwm = 1'b0;
        endcase
    end

endmodule

// File: rtl/bufpwm_timer.sv
module bufpwm_timer
    import bufpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         ovf_ie,
    input  logic         cmp_ie,
    input  logic         glob_ie,
    output logic         pwm_out,
    output logic         ovf_flag,
    output logic         cmp_flag,
    output logic         irq_ovf,
    output logic         irq_cmp
);
    localparam int FLAG_PAD = W - 2;

    logic [W-1:0] top_q, cnt, hold_val, act_val;
    logic         wrap, match, ovf_q, cmp_q;
    logic         wr_cmp, wr_top, wr_flag;

    assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
    assign wr_top  = wr_en && (wr_addr == ADDR_TOP);
    assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);

    bufpwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_en), .top(top_q),
        .cnt(cnt), .wrap(wrap)
    );

    bufpwm_cmpbuf #(.W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp), .wr_data(wr_data),
        .wrap(wrap), .hold_val(hold_val), .act_val(act_val)
    );

    bufpwm_outgen #(.W(W)) u_out (
        .mode(mode), .cnt(cnt), .act(act_val), .top(top_q), .pwm(pwm_out)
    );

    assign match = cnt_en && (cnt == act_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '1;
            ovf_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            if (wr_top) top_q <= wr_data;
            if (wrap)
                ovf_q <= 1'b1;
            else if (wr_flag && wr_data[FLAG_OVF_BIT])
                ovf_q <= 1'b0;
            if (match)
                cmp_q <= 1'b1;
            else if (wr_flag && wr_data[FLAG_CMP_BIT])
                cmp_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CMP:  rd_data = hold_val;
            ADDR_TOP:  rd_data = top_q;
            ADDR_FLAG: rd_data = {{FLAG_PAD{1'b0}}, cmp_q, ovf_q};
            default:   rd_data = '0;
        endcase
    end

    assign ovf_flag = ovf_q;
    assign cmp_flag = cmp_q;
    assign irq_ovf  = ovf_q && ovf_ie && glob_ie;
    assign irq_cmp  = cmp_q && cmp_ie && glob_ie;

    // R3: period write lands
    a_r3_top_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_top |=> (top_q == $past(wr_data)));

    // R9: disconnected modes keep the pin low
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0) |-> !pwm_out);

    // R10: wrap always sets overflow
    a_r10_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);

    // R10: clear without a competing set
    a_r10_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && wr_data[FLAG_OVF_BIT] && !wrap) |=> !ovf_flag);

    // R11: match sets compare flag
    a_r11_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag);

endmodule

// File: tb/sim_bufpwm_timer.sv
`timescale 1ns/100ps
module sim_bufpwm_timer;
    logic       clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0;
    logic [1:0] mode = 2'b00, wr_addr = 2'd0, rd_addr = 2'd0;
    logic       wr_en = 1'b0, ovf_ie = 1'b0, cmp_ie = 1'b0, glob_ie = 1'b0;
    logic [7:0] wr_data = 8'd0, rd_data;
    logic       pwm_out, ovf_flag, cmp_flag, irq_ovf, irq_cmp;

    int errors = 0, checks = 0;
    string ctx = "";
    logic [7:0] m_cnt = 0, m_top = 8'hFF, m_tmp = 0, m_act = 0;
    logic m_ovf = 0, m_cmpf = 0, m_wrapped = 0;

    always #2.5 clk = ~clk;

    bufpwm_timer #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_ie(ovf_ie),
        .cmp_ie(cmp_ie), .glob_ie(glob_ie), .pwm_out(pwm_out),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq_ovf(irq_ovf),
        .irq_cmp(irq_cmp)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_pwm();
        logic b;
        if (!mode[1]) return 1'b0;
        if (m_act == 0) b = 1'b0;
        else if (m_act >= m_top) b = 1'b1;
        else b = (m_cnt < m_act);
        return mode[0] ? !b : b;
    endfunction

    function automatic string pwm_tag();
        if (ctx != "") return ctx;
        if (!mode[1]) return "R9";
        if (m_act == 0 || m_act >= m_top) return "R8";
        return mode[0] ? "R7" : "R6";
    endfunction

    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d);
        logic wrap, match;
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        wrap  = cnt_en && (m_cnt >= m_top);
        match = cnt_en && (m_cnt == m_act);
        if (wrap) begin m_act = m_tmp; m_wrapped = 1'b1; end
        if (cnt_en) m_cnt = wrap ? 8'd0 : m_cnt + 8'd1;
        m_ovf  = wrap  ? 1'b1 : ((we && a == 2'd2 && d[0]) ? 1'b0 : m_ovf);
        m_cmpf = match ? 1'b1 : ((we && a == 2'd2 && d[1]) ? 1'b0 : m_cmpf);
        if (we && a == 2'd0) m_tmp = d;
        if (we && a == 2'd1) m_top = d;
        #1;
        wr_en = 1'b0;
        check(pwm_tag(), pwm_out, exp_pwm());
        check("R10", ovf_flag, m_ovf);
        check("R11", cmp_flag, m_cmpf);
        check("R12", irq_ovf, m_ovf & ovf_ie & glob_ie);
        check("R12", irq_cmp, m_cmpf & cmp_ie & glob_ie);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0);
    endtask

    task automatic rd(input logic [1:0] a, input string req, input int exp);
        rd_addr = a; #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic to_wrap_then_period();
        m_wrapped = 1'b0;
        while (!m_wrapped) idle(1);
        idle(int'(m_top) + 1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        rd(2'd1, "R1", 8'hFF);
        rd(2'd0, "R1", 0);
        rd(2'd2, "R1", 0);
        check("R1", pwm_out, 0);
        // R3 period write/readback
        cyc(1'b1, 2'd1, 8'd5);
        rd(2'd1, "R3", 5);
        cnt_en = 1'b1;
        // R6 R7 R8 R9 sweep over modes and compare values
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            for (int c = 0; c <= 5; c++) begin
                cyc(1'b1, 2'd0, 8'(c));
                rd(2'd0, "R4", c);
                to_wrap_then_period();
            end
        end
        // R5: write mid-period must not move the active value
        mode = 2'b10;
        cyc(1'b1, 2'd0, 8'd1);
        to_wrap_then_period();
        while (m_cnt != 8'd2) idle(1);
        ctx = "R5";
        cyc(1'b1, 2'd0, 8'd4);
        rd(2'd0, "R4", 4);
        check("R5", pwm_out, 0);
        to_wrap_then_period();
        ctx = "";
        // R10 R11: clear by 1, zero write ignored
        cyc(1'b1, 2'd2, 8'd0);
        rd(2'd2, "R10", {6'd0, m_cmpf, m_ovf});
        while (m_cnt != 8'd2) idle(1);
        cyc(1'b1, 2'd2, 8'd3);
        rd(2'd2, "R11", {6'd0, m_cmpf, m_ovf});
        // R10 set wins over clear at wrap
        while (m_cnt != 8'd5) idle(1);
        cyc(1'b1, 2'd2, 8'd1);
        check("R10", ovf_flag, 1);
        // R12 interrupt gating
        for (int k = 0; k < 8; k++) begin
            ovf_ie = k[0]; cmp_ie = k[1]; glob_ie = k[2];
            idle(3);
        end
        // R2 hold with enable low: clear flags, stop, observe
        cnt_en = 1'b0;
        cyc(1'b1, 2'd2, 8'd3);
        begin
            logic p0;
            p0 = pwm_out;
            for (int i = 0; i < 10; i++) begin
                idle(1);
                check("R2", pwm_out, p0);
                check("R2", ovf_flag, 0);
            end
        end
        cnt_en = 1'b1;
        idle(12);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule